// File: doc/BRIEF.md
# Snooping Four-State Cache Line Controller

This block keeps the coherence state of every line in a small direct-mapped data cache that sits on a shared bus with other caches. Each line holds one data word, an address tag and one of four states: Modified, Exclusive, Shared or Invalid. The block serves local processor reads and writes, and also watches the transactions that other masters put on the bus. Both kinds of event move the line states. The state of the addressed line decides which bus operation, if any, a local access needs.

A processor access is presented with `cpu_req` and held stable until `cpu_done` pulses. A hit that needs no bus operation completes in the cycle it is seen. Any other access raises `bus_req` with a command, and the access finishes in the cycle the grant arrives. The command is worked out again from the line's current state in every cycle, so a snoop that lands during the wait changes what is finally issued. A snooped transaction always takes precedence for its cycle. In that same cycle the snoop side drives a shared response and, when the line is dirty, a copyback word.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. A line counts as present only when its stored tag equals the upper address bits (address bits above the low `IDX_W` index bits) and its state is not Invalid. The first access to any address therefore needs the bus, and a snoop of an address that only shares the index gets no shared response.
- R2: A read that hits a valid line asserts `cpu_done` in the same cycle with the stored word on `cpu_rdata`. It raises no `bus_req` and leaves the state unchanged.
- R3: A write that hits a Modified or Exclusive line completes in the same cycle with no bus operation. It stores the word and leaves the line Modified.
- R4: A write that hits a Shared line requests an invalidate (`bus_cmd` = 2, address = the access address). When granted, it stores the word and leaves the line Modified.
- R5: A read miss requests a bus read (`bus_cmd` = 0). In the grant cycle, `cpu_rdata` is `bus_rdata` and `cpu_done` pulses. The line fills as Shared if `bus_shared` is high in that cycle, and as Exclusive otherwise.
- R6: A write miss requests a read-with-intent-to-modify (`bus_cmd` = 1). When granted, the line fills as Modified with the written word.
- R7: A miss on an index whose current line is Modified first requests a copyback (`bus_cmd` = 3). That request carries the old line's address `{old tag, index}` on `bus_addr` and its word on `bus_wdata`. Once granted, the line becomes Invalid and the access goes on to its fill. A copyback grant does not complete the access.
- R8: A snooped read (`snp_wr` = 0) that hits a valid line raises `snp_shared` in the same cycle. If the line is Modified, `snp_copyback` is raised with the word on `snp_wdata`. A Modified or Exclusive line becomes Shared.
- R9: A snooped write or read-with-intent-to-modify (`snp_wr` = 1) that hits a valid line raises no `snp_shared`. It raises `snp_copyback` with the word if the line was Modified, and it leaves the line Invalid.
- R10: In a cycle with `snp_valid` high the processor side neither requests the bus nor completes. A pending access then re-evaluates: a write waiting to invalidate a Shared line that the snoop killed asks for a read-with-intent-to-modify instead.
- R11: `cpu_busy` is high exactly while `cpu_req` is high and the access has not completed in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access pending |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Access line address |
| cpu_wdata | input | DATA_W | Write word |
| cpu_busy | output | 1 | Processor must wait |
| cpu_done | output | 1 | Access completes this cycle |
| cpu_rdata | output | DATA_W | Read word, valid with `cpu_done` |
| bus_req | output | 1 | Bus operation requested |
| bus_cmd | output | 2 | 0 read, 1 read-with-intent-to-modify, 2 invalidate, 3 copyback |
| bus_addr | output | ADDR_W | Address of requested operation |
| bus_wdata | output | DATA_W | Copyback word |
| bus_gnt | input | 1 | Request granted; operation takes place this cycle |
| bus_rdata | input | DATA_W | Fill word from memory in the grant cycle |
| bus_shared | input | 1 | Another cache holds the line (grant cycle of a read) |
| snp_valid | input | 1 | Another master's transaction seen on the bus |
| snp_wr | input | 1 | Snooped transaction is a write or read-with-intent-to-modify |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | Line held here (snooped reads) |
| snp_copyback | output | 1 | Dirty line is being written back |
| snp_wdata | output | DATA_W | Copyback word for snoop |

## Verification
Each line is led through every state by a chain of directed local reads, writes and snoops: fills with and without the shared signal, write hits in each state, and snooped reads and writes on dirty, clean and invalid lines. A line's hidden state is exposed only through what comes next: the bus command of the following write, and whether a snoop answers with a copyback. Two address patterns share an index but differ in tag, one to force a victim copyback ahead of a fill and one to show that a snoop with a mismatched tag is ignored. A snoop injected while a write waits for its grant separates re-evaluation from a stale, latched command.

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_busy,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_shared,
  input  logic              snp_valid,
  input  logic              snp_wr,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_copyback,
  output logic [DATA_W-1:0] snp_wdata
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3;
  localparam logic [1:0] CMD_READ = 2'd0, CMD_RWITM = 2'd1, CMD_INVAL = 2'd2, CMD_CB = 2'd3;

  logic [1:0]        st [LINES];
  logic [TAG_W-1:0]  tg [LINES];
  logic [DATA_W-1:0] dt [LINES];

  wire [IDX_W-1:0] c_idx = cpu_addr[IDX_W-1:0];
  wire [TAG_W-1:0] c_tag = cpu_addr[ADDR_W-1:IDX_W];
  wire [1:0]       c_st  = st[c_idx];
  wire             c_hit = (c_st != ST_I) && (tg[c_idx] == c_tag);
  wire             c_act = cpu_req && !snp_valid;

  wire [IDX_W-1:0] s_idx = snp_addr[IDX_W-1:0];
  wire [TAG_W-1:0] s_tag = snp_addr[ADDR_W-1:IDX_W];
  wire [1:0]       s_st  = st[s_idx];
  wire             s_hit = snp_valid && (s_st != ST_I) && (tg[s_idx] == s_tag);

  wire quiet   = c_hit && (!cpu_we || c_st[1]);
  wire granted = bus_req && bus_gnt;

  always_comb begin
    if (c_hit)             bus_cmd = CMD_INVAL;
    else if (c_st == ST_M) bus_cmd = CMD_CB;
    else                   bus_cmd = cpu_we ? CMD_RWITM : CMD_READ;
  end

  assign bus_req   = c_act && !quiet;
  assign bus_addr  = (bus_cmd == CMD_CB) ? {tg[c_idx], c_idx} : cpu_addr;
  assign bus_wdata = dt[c_idx];
  assign cpu_done  = (c_act && quiet) || (granted && bus_cmd != CMD_CB);
  assign cpu_rdata = c_hit ? dt[c_idx] : bus_rdata;
  assign cpu_busy  = cpu_req && !cpu_done;

  assign snp_shared   = s_hit && !snp_wr;
  assign snp_copyback = s_hit && (s_st == ST_M);
  assign snp_wdata    = dt[s_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st[i] <= ST_I;
        tg[i] <= '0;
        dt[i] <= '0;
      end
    end else begin
      if (s_hit) st[s_idx] <= snp_wr ? ST_I : ST_S;
      if (c_act && quiet && cpu_we) begin
        st[c_idx] <= ST_M;
        dt[c_idx] <= cpu_wdata;
      end else if (granted) begin
        case (bus_cmd)
          CMD_READ: begin
            st[c_idx] <= bus_shared ? ST_S : ST_E;
            tg[c_idx] <= c_tag;
            dt[c_idx] <= bus_rdata;
          end
          CMD_RWITM: begin
            st[c_idx] <= ST_M;
            tg[c_idx] <= c_tag;
            dt[c_idx] <= cpu_wdata;
          end
          CMD_INVAL: begin
            st[c_idx] <= ST_M;
            dt[c_idx] <= cpu_wdata;
          end
          default: st[c_idx] <= ST_I;
        endcase
      end
    end
  end

  AST_SNOOP_READ_DEMOTES: assert property (@(posedge clk) disable iff (!rst_n)
    (s_hit && !snp_wr) |=> st[$past(s_idx)] == ST_S); // R8
  AST_SNOOP_WRITE_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (s_hit && snp_wr) |=> st[$past(s_idx)] == ST_I); // R9
  AST_WRITE_LEAVES_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_done && cpu_we) |=> st[$past(c_idx)] == ST_M); // R3
  AST_READ_FILL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (granted && bus_cmd == CMD_READ) |=> st[$past(c_idx)] == ($past(bus_shared) ? ST_S : ST_E)); // R5
  AST_COPYBACK_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (granted && bus_cmd == CMD_CB) |=> st[$past(c_idx)] == ST_I); // R7
  AST_SNOOP_HOLDS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> (!bus_req && !cpu_done)); // R10
endmodule

// File: tb/mesi_line_ctrl_test.sv
module mesi_line_ctrl_test;
  localparam int AW = 8, IW = 2, DW = 8, NL = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cpu_req, cpu_we, bus_gnt, bus_shared, snp_valid, snp_wr, gnt_en;
  logic [AW-1:0] cpu_addr, bus_addr, snp_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata, bus_wdata, bus_rdata, snp_wdata;
  logic cpu_busy, cpu_done, bus_req, snp_shared, snp_copyback;
  logic [1:0] bus_cmd;
  logic [DW-1:0] mem [256];

  assign bus_gnt   = gnt_en & bus_req;
  assign bus_rdata = mem[bus_addr];

  mesi_line_ctrl #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_gnt(bus_gnt), .bus_rdata(bus_rdata), .bus_shared(bus_shared), .snp_valid(snp_valid),
    .snp_wr(snp_wr), .snp_addr(snp_addr), .snp_shared(snp_shared),
    .snp_copyback(snp_copyback), .snp_wdata(snp_wdata));

  int nchk = 0, nerr = 0;
  int m_st [NL], m_tg [NL], m_dt [NL];
  int e_req, e_cmd, e_addr, e_wd, e_done, e_rd, e_shr, e_cb, e_cbd;
  int cmd_q [$], addr_q [$];
  int s_done, s_rd, s_shr, s_cb, s_cbd, s_busy, s_req, s_cmd;
  int acc_cycles, acc_rd, first_busy;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic model_eval();
    int ci, ct, si, stg;
    bit hit;
    e_req = 0; e_done = 0; e_shr = 0; e_cb = 0; e_cmd = 0; e_addr = 0; e_wd = 0; e_rd = 0; e_cbd = 0;
    if (snp_valid) begin
      si = int'(snp_addr) % NL; stg = int'(snp_addr) / NL;
      hit = m_st[si] != 0 && m_tg[si] == stg;
      e_shr = int'(hit && !snp_wr);
      e_cb = int'(hit && m_st[si] == 3);
      e_cbd = m_dt[si];
    end
    if (cpu_req && !snp_valid) begin
      ci = int'(cpu_addr) % NL; ct = int'(cpu_addr) / NL;
      hit = m_st[ci] != 0 && m_tg[ci] == ct;
      if (hit && (!cpu_we || m_st[ci] >= 2)) begin
        e_done = 1; e_rd = m_dt[ci];
      end else begin
        e_req = 1;
        if (hit) begin e_cmd = 2; e_addr = int'(cpu_addr); end
        else if (m_st[ci] == 3) begin e_cmd = 3; e_addr = m_tg[ci] * NL + ci; e_wd = m_dt[ci]; end
        else begin e_cmd = cpu_we ? 1 : 0; e_addr = int'(cpu_addr); end
        if (gnt_en && e_cmd != 3) begin e_done = 1; e_rd = int'(mem[cpu_addr]); end
      end
    end
  endtask

  task automatic model_update();
    int ci, ct, si;
    if (e_shr != 0 || e_cb != 0 || (snp_valid && snp_wr)) begin
      si = int'(snp_addr) % NL;
      if (m_st[si] != 0 && m_tg[si] == int'(snp_addr) / NL) begin
        if (m_st[si] == 3) mem[snp_addr] = DW'(m_dt[si]);
        m_st[si] = snp_wr ? 0 : 1;
      end
    end
    ci = int'(cpu_addr) % NL; ct = int'(cpu_addr) / NL;
    if (e_done != 0 && e_req == 0 && cpu_we) begin
      m_st[ci] = 3; m_dt[ci] = int'(cpu_wdata);
    end else if (e_req != 0 && gnt_en) begin
      case (e_cmd)
        0: begin m_st[ci] = bus_shared ? 1 : 2; m_tg[ci] = ct; m_dt[ci] = int'(mem[cpu_addr]); end
        1: begin m_st[ci] = 3; m_tg[ci] = ct; m_dt[ci] = int'(cpu_wdata); end
        2: begin m_st[ci] = 3; m_dt[ci] = int'(cpu_wdata); end
        default: begin mem[e_addr] = DW'(e_wd); m_st[ci] = 0; end
      endcase
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (!rst_n) begin
      for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_tg[i] = 0; m_dt[i] = 0; end
    end else begin
      model_eval();
      chk(int'(bus_req) == e_req, "R10 bus_req per cycle", int'(bus_req), e_req);
      if (e_req != 0 && bus_req) begin
        chk(int'(bus_cmd) == e_cmd, "R4 bus_cmd per cycle", int'(bus_cmd), e_cmd);
        chk(int'(bus_addr) == e_addr, "R7 bus_addr per cycle", int'(bus_addr), e_addr);
        if (e_cmd == 3) chk(int'(bus_wdata) == e_wd, "R7 bus_wdata per cycle", int'(bus_wdata), e_wd);
      end
      chk(int'(cpu_done) == e_done, "R2 cpu_done per cycle", int'(cpu_done), e_done);
      if (e_done != 0 && !cpu_we) chk(int'(cpu_rdata) == e_rd, "R5 cpu_rdata per cycle", int'(cpu_rdata), e_rd);
      chk(int'(cpu_busy) == int'(cpu_req && e_done == 0), "R11 cpu_busy per cycle", int'(cpu_busy), int'(cpu_req && e_done == 0));
      chk(int'(snp_shared) == e_shr, "R8 snp_shared per cycle", int'(snp_shared), e_shr);
      chk(int'(snp_copyback) == e_cb, "R9 snp_copyback per cycle", int'(snp_copyback), e_cb);
      if (e_cb != 0) chk(int'(snp_wdata) == e_cbd, "R9 snp_wdata per cycle", int'(snp_wdata), e_cbd);
      if (bus_req && bus_gnt) begin cmd_q.push_back(int'(bus_cmd)); addr_q.push_back(int'(bus_addr)); end
      s_done = int'(cpu_done); s_rd = int'(cpu_rdata); s_shr = int'(snp_shared);
      s_cb = int'(snp_copyback); s_cbd = int'(snp_wdata); s_busy = int'(cpu_busy);
      s_req = int'(bus_req); s_cmd = int'(bus_cmd);
      model_update();
    end
    @(posedge clk);
    #1;
  endtask

  task automatic access(input bit we, input int addr, input int wd, input bit shr, input int dly);
    int n = 0;
    bit got = 0;
    cmd_q.delete(); addr_q.delete();
    cpu_req = 1; cpu_we = we; cpu_addr = AW'(addr); cpu_wdata = DW'(wd); bus_shared = shr;
    while (!got && n < 60) begin
      gnt_en = (n >= dly);
      step();
      if (n == 0) first_busy = s_busy;
      if (s_done != 0) begin got = 1; acc_rd = s_rd; end
      n++;
    end
    acc_cycles = n;
    cpu_req = 0; gnt_en = 0; bus_shared = 0;
    if (!got) chk(0, "R11 access never completed", n, 0);
  endtask

  task automatic snoop(input bit wr, input int addr);
    snp_valid = 1; snp_wr = wr; snp_addr = AW'(addr);
    step();
    snp_valid = 0; snp_wr = 0;
  endtask

  initial begin
    #(4 * 20000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = DW'(i) ^ 8'h5A;
    rst_n = 0; cpu_req = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0;
    bus_shared = 0; snp_valid = 0; snp_wr = 0; snp_addr = 0; gnt_en = 0;
    step(); step();
    rst_n = 1;
    step();
    chk(s_busy == 0 && s_req == 0, "R1 idle after reset", s_req, 0);
    snoop(0, 'h11);
    chk(s_shr == 0, "R1 snoop after reset misses", s_shr, 0);

    access(0, 'h11, 0, 0, 2);
    chk(cmd_q.size() == 1 && cmd_q[0] == 0, "R1 first read uses bus read", cmd_q.size(), 1);
    chk(acc_rd == 'h4B, "R5 read fill data", acc_rd, 'h4B);
    chk(acc_cycles == 3, "R11 waits for grant", acc_cycles, 3);
    chk(first_busy == 1, "R11 busy while waiting", first_busy, 1);

    access(0, 'h11, 0, 0, 0);
    chk(cmd_q.size() == 0 && acc_cycles == 1, "R2 read hit quiet", cmd_q.size(), 0);
    chk(acc_rd == 'h4B, "R2 read hit data", acc_rd, 'h4B);

    access(1, 'h11, 'hA1, 0, 0);
    chk(cmd_q.size() == 0 && acc_cycles == 1, "R3 write hit on Exclusive quiet", cmd_q.size(), 0);
    snoop(0, 'h11);
    chk(s_shr == 1 && s_cb == 1, "R8 snoop read of dirty line", s_cb, 1);
    chk(s_cbd == 'hA1, "R8 copyback word", s_cbd, 'hA1);
    chk(int'(mem['h11]) == 'hA1, "R8 memory updated", int'(mem['h11]), 'hA1);

    access(1, 'h11, 'hB2, 0, 0);
    chk(cmd_q.size() == 1 && cmd_q[0] == 2, "R4 write hit on Shared invalidates", cmd_q.size() ? cmd_q[0] : -1, 2);
    snoop(1, 'h11);
    chk(s_shr == 0 && s_cb == 1 && s_cbd == 'hB2, "R9 snoop write of dirty line", s_cbd, 'hB2);
    access(0, 'h11, 0, 1, 0);
    chk(cmd_q.size() == 1 && cmd_q[0] == 0, "R9 line invalid after snoop write", cmd_q.size(), 1);
    chk(acc_rd == 'hB2, "R5 fill sees copied-back word", acc_rd, 'hB2);
    snoop(0, 'h11);
    chk(s_shr == 1 && s_cb == 0, "R5 shared fill is clean", s_cb, 0);

    access(1, 'h22, 'hC3, 0, 1);
    chk(cmd_q.size() == 1 && cmd_q[0] == 1, "R6 write miss uses intent-to-modify", cmd_q.size() ? cmd_q[0] : -1, 1);
    snoop(0, 'h22);
    chk(s_cb == 1 && s_cbd == 'hC3, "R6 filled as Modified", s_cbd, 'hC3);

    access(1, 'h27, 'hD4, 0, 0);
    access(0, 'h47, 0, 0, 1);
    chk(cmd_q.size() == 2 && cmd_q[0] == 3 && cmd_q[1] == 0, "R7 copyback before fill", cmd_q.size(), 2);
    chk(addr_q.size() == 2 && addr_q[0] == 'h27 && addr_q[1] == 'h47, "R7 victim address", addr_q.size() ? addr_q[0] : -1, 'h27);
    chk(int'(mem['h27]) == 'hD4, "R7 victim word in memory", int'(mem['h27]), 'hD4);
    chk(acc_rd == ('h47 ^ 'h5A), "R7 fill after copyback", acc_rd, 'h47 ^ 'h5A);

    snoop(1, 'h47);
    chk(s_shr == 0 && s_cb == 0, "R9 snoop write of clean line", s_cb, 0);
    access(0, 'h47, 0, 0, 0);
    chk(cmd_q.size() == 1 && cmd_q[0] == 0, "R9 clean line invalidated", cmd_q.size(), 1);

    cpu_req = 1; cpu_we = 1; cpu_addr = 'h11; cpu_wdata = 'hE5; gnt_en = 0;
    step();
    chk(s_req == 1 && s_cmd == 2, "R4 pending invalidate", s_cmd, 2);
    snp_valid = 1; snp_wr = 1; snp_addr = 'h11;
    step();
    snp_valid = 0; snp_wr = 0;
    chk(s_req == 0 && s_done == 0, "R10 snoop takes the cycle", s_req, 0);
    step();
    chk(s_req == 1 && s_cmd == 1, "R10 re-evaluated to intent-to-modify", s_cmd, 1);
    gnt_en = 1;
    step();
    chk(s_done == 1, "R10 completes after grant", s_done, 1);
    cpu_req = 0; gnt_en = 0;
    snoop(0, 'h11);
    chk(s_cb == 1 && s_cbd == 'hE5, "R10 line ends Modified", s_cbd, 'hE5);

    access(0, 'h30, 0, 0, 0);
    snoop(0, 'h30);
    chk(s_shr == 1 && s_cb == 0, "R8 snoop read of Exclusive line", s_shr, 1);
    access(1, 'h30, 'hF6, 0, 0);
    chk(cmd_q.size() == 1 && cmd_q[0] == 2, "R8 Exclusive dropped to Shared", cmd_q.size() ? cmd_q[0] : -1, 2);
    snoop(0, 'h70);
    chk(s_shr == 0 && s_cb == 0, "R1 tag mismatch is no hit", s_shr, 0);
    snoop(0, 'h30);
    chk(s_cb == 1 && s_cbd == 'hF6, "R1 mismatched snoop left line intact", s_cbd, 'hF6);

    step();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule